// File: doc/BRIEF.md
# LCD Demultiplexer Sample-Pulse Sequencer

This block is the digital timing core of a six-channel analog demultiplexer that feeds a thin-film LCD panel. Once per video line a horizontal reference pulse arrives. The sequencer turns it into a train of one-hot first-stage sample strobes, one per channel, in scan order. It also produces second-stage transfer strobes for the lower channel group (channels 1 to 3) and the upper group (channels 4 to 6). The analog sample-and-hold cells, buffers and clock phase shifter sit outside this block and only consume these strobes.

Two devices can share one analog stream in paired mode. The master device strobes on the even dot clocks and the slave on the odd ones, so the panel sees master channel 1, slave channel 1, master channel 2 and so on. A 4-bit phase code moves the whole train in whole dot clocks relative to the reference pulse. The reference pulse can be sampled on either clock edge, to recover timing margin on a long board trace.

A timing monitor watches the framing inputs: enable width, reference width, reference spacing, and invert-flag changes that happen without a reference pulse. Any broken rule sets a sticky error flag. The monitor never stalls or alters the strobe train.

Top module: `lcd_demux_sequencer`

## Requirements
- R1: A synchronous active-high reset clears all strobe outputs and the error flag by the first clock edge that samples `rst` high, and keeps them clear while `rst` is held.
- R2: With `scan_fwd`=1, the sample strobes step through channels 1,2,3,4,5,6 and then wrap to 1. Bit i of `sample_stb` belongs to channel i+1.
- R3: With `scan_fwd`=0, the strobes step 6,5,4,3,2,1 and then wrap to 6.
- R4: At most one bit of `sample_stb` is high in any cycle. In single mode (`pair_mode`=0) a new channel is strobed every cycle. In paired mode a channel is strobed every second cycle and stays high for one cycle.
- R5: In paired mode a slave (`slave_sel`=1) starts one cycle later than a master (`slave_sel`=0) with the same phase code. The two devices therefore interleave channel by channel.
- R6: Call E the clock edge that first sees the reference pulse high. The first strobe is visible in the cycle after edge E+d, where d is `phase_code` (0 to 15), plus one for a paired slave.
- R7: With `ref_on_fall`=1 the reference level is taken at the falling clock edge that precedes each rising edge. With `ref_on_fall`=0 it is taken at the rising edge itself.
- R8: A strobe or transfer output can be high only in a cycle that follows a rising edge at which `enable` was sampled high.
- R9: A new reference pulse during a running sequence restarts it. The phase delay is reloaded and the pointer returns to the first channel of the scan direction.
- R10: Direction, role, paired mode, transfer split and phase code are captured at edge E. Changing them later in the line has no effect until the next reference pulse.
- R11: Transfers follow the strobe of the channel that closes a group, registered one cycle later. With `split_xfer`=1, `xfer_lo` follows the last-scanned channel of 1–3 and `xfer_hi` the last-scanned of 4–6. With `split_xfer`=0, both pulse together after the last channel of the whole pass.
- R12: `timing_err` goes high and stays high until reset if any of these happens: `enable` is high for fewer than 30 consecutive sampled edges; the reference is high for fewer than 4 sampled edges; two reference rising edges are fewer than 60 edges apart.
- R13: A change of `invert` that is seen more than 5 edges after the last reference rising edge, or before any reference pulse, sets `timing_err`. The strobe sequence goes on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_pulse | input | 1 | Horizontal reference pulse |
| ref_on_fall | input | 1 | 1: sample reference on falling edge, 0: on rising edge |
| enable | input | 1 | Enable window for strobe output |
| invert | input | 1 | Line polarity-invert flag (monitored only) |
| scan_fwd | input | 1 | 1: ascending channel order, 0: descending |
| slave_sel | input | 1 | 0: master, 1: slave |
| pair_mode | input | 1 | 1: two devices interleaved (12 channels) |
| split_xfer | input | 1 | 1: groups transfer separately, 0: together |
| phase_code | input | 4 | Start offset in dot clocks |
| sample_stb | output | 6 | One-hot first-stage sample strobes |
| xfer_lo | output | 1 | Transfer strobe, channels 1–3 |
| xfer_hi | output | 1 | Transfer strobe, channels 4–6 |
| timing_err | output | 1 | Sticky input-timing violation flag |

## Verification
The bench aims at the wrap points in both scan directions. A pointer that stepped the wrong way or skipped the wrap shows up as a wrong one-hot vector at the seventh strobe. It checks the maximum phase code and the extra slave cycle, where an off-by-one start lands the whole train one clock early or late. Each timing rule is probed exactly at its limit (3 versus 4 reference edges, 59 versus 60 spacing, an invert change at 5 versus 6 edges): an inclusive/exclusive slip raises the flag on legal input or misses a real violation. A mid-line restart and a mid-line configuration change expose a design that keeps its old pointer or reads live configuration.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    // Line configuration captured at the reference pulse.
    typedef struct packed {
        logic fwd;
        logic pair;
        logic slave;
        logic split;
    } seq_cfg_t;

    function automatic int first_idx(input logic fwd, input int n);
        return fwd ? 0 : n - 1;
    endfunction

    function automatic int next_idx(input int idx, input logic fwd, input int n);
        if (fwd) return (idx == n - 1) ? 0 : idx + 1;
        return (idx == 0) ? n - 1 : idx - 1;
    endfunction

    // Channel that closes the lower group in scan order.
    function automatic int lo_close(input logic fwd, input int n);
        return fwd ? (n / 2) - 1 : 0;
    endfunction

    // Channel that closes the upper group in scan order.
    function automatic int hi_close(input logic fwd, input int n);
        return fwd ? n - 1 : n / 2;
    endfunction

    // Channel that closes a whole pass.
    function automatic int pass_close(input logic fwd, input int n);
        return fwd ? n - 1 : 0;
    endfunction

endpackage

// File: rtl/lcd_seq_frontend.sv
module lcd_seq_frontend (
    input  logic clk,
    input  logic rst,
    input  logic ref_pulse,
    input  logic ref_on_fall,
    input  logic enable,
    output logic ref_lvl,
    output logic ref_rise,
    output logic ref_fall,
    output logic en_q,
    output logic en_fall
);
    logic ref_neg_q;
    logic ref_q;

    // Falling-edge capture path for the reference pulse.
    always_ff @(negedge clk) begin
        if (rst) ref_neg_q <= 1'b0;
        else     ref_neg_q <= ref_pulse;
    end

    assign ref_lvl = ref_on_fall ? ref_neg_q : ref_pulse;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= 1'b0;
            en_q  <= 1'b0;
        end else begin
            ref_q <= ref_lvl;
            en_q  <= enable;
        end
    end

    assign ref_rise = ref_lvl & ~ref_q;
    assign ref_fall = ~ref_lvl & ref_q;
    assign en_fall  = ~enable & en_q;

endmodule

// File: rtl/lcd_seq_core.sv
module lcd_seq_core
    import lcd_seq_pkg::*;
#(
    parameter int NUM_CH  = 6,
    parameter int PHASE_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_rise,
    input  logic               en_q,
    input  seq_cfg_t           cfg_in,
    input  logic [PHASE_W-1:0] phase_code,
    output logic [NUM_CH-1:0]  sample_stb,
    output logic               xfer_lo,
    output logic               xfer_hi
);
    localparam int PTR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int DLY_W = PHASE_W + 1;

    seq_cfg_t         cfg_q;
    logic [PTR_W-1:0] ptr_q;
    logic [DLY_W-1:0] cnt_q;
    logic             active_q;
    logic             ph_q;
    logic             xlo_q;
    logic             xhi_q;
    logic             fire;
    logic             stb_live;
    logic [DLY_W-1:0] start_dly;

    assign fire     = active_q && (cnt_q == '0) && (!cfg_q.pair || !ph_q);
    assign stb_live = fire && en_q;
    assign start_dly = DLY_W'(phase_code) + DLY_W'(cfg_in.pair & cfg_in.slave);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_stb
        assign sample_stb[g] = stb_live && (int'(ptr_q) == g);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            ptr_q    <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
            ph_q     <= 1'b0;
            xlo_q    <= 1'b0;
            xhi_q    <= 1'b0;
        end else begin
            if (stb_live) begin
                xlo_q <= cfg_q.split ? (int'(ptr_q) == lo_close(cfg_q.fwd, NUM_CH))
                                     : (int'(ptr_q) == pass_close(cfg_q.fwd, NUM_CH));
                xhi_q <= cfg_q.split ? (int'(ptr_q) == hi_close(cfg_q.fwd, NUM_CH))
                                     : (int'(ptr_q) == pass_close(cfg_q.fwd, NUM_CH));
            end else begin
                xlo_q <= 1'b0;
                xhi_q <= 1'b0;
            end

            if (ref_rise) begin
                cfg_q    <= cfg_in;
                cnt_q    <= start_dly;
                ptr_q    <= PTR_W'(first_idx(cfg_in.fwd, NUM_CH));
                ph_q     <= 1'b0;
                active_q <= 1'b1;
            end else if (active_q) begin
                if (cnt_q != '0) begin
                    cnt_q <= cnt_q - 1'b1;
                end else begin
                    if (!cfg_q.pair || ph_q)
                        ptr_q <= PTR_W'(next_idx(int'(ptr_q), cfg_q.fwd, NUM_CH));
                    if (cfg_q.pair)
                        ph_q <= ~ph_q;
                end
            end
        end
    end

    assign xfer_lo = xlo_q & en_q;
    assign xfer_hi = xhi_q & en_q;

endmodule

// File: rtl/lcd_seq_monitor.sv
module lcd_seq_monitor #(
    parameter int CNT_W   = 8,
    parameter int MIN_EN  = 30,
    parameter int MIN_REF = 4,
    parameter int MIN_GAP = 60,
    parameter int INV_WIN = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic en_fall,
    input  logic ref_lvl,
    input  logic ref_rise,
    input  logic ref_fall,
    input  logic invert,
    output logic timing_err
);
    localparam logic [CNT_W-1:0] SAT     = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] LIM_EN  = CNT_W'(MIN_EN);
    localparam logic [CNT_W-1:0] LIM_REF = CNT_W'(MIN_REF);
    localparam logic [CNT_W-1:0] LIM_GAP = CNT_W'(MIN_GAP);
    localparam logic [CNT_W-1:0] LIM_INV = CNT_W'(INV_WIN);

    logic [CNT_W-1:0] en_cnt_q;
    logic [CNT_W-1:0] ref_cnt_q;
    logic [CNT_W-1:0] since_q;
    logic             seen_q;
    logic             inv_q;
    logic             err_q;

    typedef struct packed {
        logic en_short;
        logic ref_short;
        logic ref_close;
        logic inv_stray;
    } viol_t;

    viol_t viol;

    always_comb begin
        viol.en_short  = en_fall && (en_cnt_q < LIM_EN);
        viol.ref_short = ref_fall && (ref_cnt_q < LIM_REF);
        viol.ref_close = ref_rise && seen_q && (since_q < LIM_GAP);
        viol.inv_stray = (invert ^ inv_q) && !(ref_rise || (seen_q && since_q <= LIM_INV));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_cnt_q  <= '0;
            ref_cnt_q <= '0;
            since_q   <= '0;
            seen_q    <= 1'b0;
            inv_q     <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            err_q     <= err_q | (|viol);
            inv_q     <= invert;
            en_cnt_q  <= enable  ? ((en_cnt_q  == SAT) ? SAT : en_cnt_q  + 1'b1) : '0;
            ref_cnt_q <= ref_lvl ? ((ref_cnt_q == SAT) ? SAT : ref_cnt_q + 1'b1) : '0;
            if (ref_rise) begin
                since_q <= CNT_W'(1);
                seen_q  <= 1'b1;
            end else if (seen_q && since_q != SAT) begin
                since_q <= since_q + 1'b1;
            end
        end
    end

    assign timing_err = err_q;

endmodule

// File: rtl/lcd_demux_sequencer.sv
module lcd_demux_sequencer
    import lcd_seq_pkg::*;
#(
    parameter int NUM_CH  = 6,
    parameter int PHASE_W = 4,
    parameter int CNT_W   = 8,
    parameter int MIN_EN  = 30,
    parameter int MIN_REF = 4,
    parameter int MIN_GAP = 60,
    parameter int INV_WIN = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_pulse,
    input  logic               ref_on_fall,
    input  logic               enable,
    input  logic               invert,
    input  logic               scan_fwd,
    input  logic               slave_sel,
    input  logic               pair_mode,
    input  logic               split_xfer,
    input  logic [PHASE_W-1:0] phase_code,
    output logic [NUM_CH-1:0]  sample_stb,
    output logic               xfer_lo,
    output logic               xfer_hi,
    output logic               timing_err
);
    logic     ref_lvl;
    logic     ref_rise;
    logic     ref_fall;
    logic     en_q;
    logic     en_fall;
    seq_cfg_t cfg_in;

    assign cfg_in = '{fwd: scan_fwd, pair: pair_mode, slave: slave_sel, split: split_xfer};

    lcd_seq_frontend u_front (
        .clk        (clk),
        .rst        (rst),
        .ref_pulse  (ref_pulse),
        .ref_on_fall(ref_on_fall),
        .enable     (enable),
        .ref_lvl    (ref_lvl),
        .ref_rise   (ref_rise),
        .ref_fall   (ref_fall),
        .en_q       (en_q),
        .en_fall    (en_fall)
    );

    lcd_seq_core #(
        .NUM_CH (NUM_CH),
        .PHASE_W(PHASE_W)
    ) u_core (
        .clk       (clk),
        .rst       (rst),
        .ref_rise  (ref_rise),
        .en_q      (en_q),
        .cfg_in    (cfg_in),
        .phase_code(phase_code),
        .sample_stb(sample_stb),
        .xfer_lo   (xfer_lo),
        .xfer_hi   (xfer_hi)
    );

    lcd_seq_monitor #(
        .CNT_W  (CNT_W),
        .MIN_EN (MIN_EN),
        .MIN_REF(MIN_REF),
        .MIN_GAP(MIN_GAP),
        .INV_WIN(INV_WIN)
    ) u_mon (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .en_fall   (en_fall),
        .ref_lvl   (ref_lvl),
        .ref_rise  (ref_rise),
        .ref_fall  (ref_fall),
        .invert    (invert),
        .timing_err(timing_err)
    );

endmodule

// File: rtl/lcd_demux_sequencer_chk.sv
module lcd_demux_sequencer_chk #(
    parameter int NUM_CH = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              enable,
    input logic [NUM_CH-1:0] sample_stb,
    input logic              xfer_lo,
    input logic              xfer_hi,
    input logic              timing_err
);
    AST_RST_CLEAR: assert property (@(posedge clk)
        rst |=> (sample_stb == '0 && !xfer_lo && !xfer_hi && !timing_err)); // R1

    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sample_stb)); // R4

    AST_STB_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (|sample_stb) |-> $past(enable)); // R8

    AST_XFER_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (xfer_lo || xfer_hi) |-> $past(enable)); // R8

    AST_XFER_AFTER_STB: assert property (@(posedge clk) disable iff (rst)
        (xfer_lo || xfer_hi) |-> $past(|sample_stb)); // R11

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        timing_err |=> timing_err); // R12

endmodule

bind lcd_demux_sequencer lcd_demux_sequencer_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .sample_stb(sample_stb),
    .xfer_lo   (xfer_lo),
    .xfer_hi   (xfer_hi),
    .timing_err(timing_err)
);

// File: tb/lcd_demux_sequencer_bench.sv
module lcd_demux_sequencer_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_pulse = 1'b0, ref_on_fall = 1'b0, enable = 1'b0, invert = 1'b0;
    logic       scan_fwd = 1'b1, slave_sel = 1'b0, pair_mode = 1'b0, split_xfer = 1'b0;
    logic [3:0] phase_code = 4'd0;
    logic [5:0] sample_stb;
    logic       xfer_lo, xfer_hi, timing_err;

    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    logic [5:0] cap_s [0:199];
    logic       cap_l [0:199];
    logic       cap_h [0:199];
    logic       cap_e [0:199];

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_demux_sequencer u_lcd_demux_sequencer (
        .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .ref_on_fall(ref_on_fall),
        .enable(enable), .invert(invert), .scan_fwd(scan_fwd), .slave_sel(slave_sel),
        .pair_mode(pair_mode), .split_xfer(split_xfer), .phase_code(phase_code),
        .sample_stb(sample_stb), .xfer_lo(xfer_lo), .xfer_hi(xfer_hi), .timing_err(timing_err)
    );

    // ---------------- behavioural expectation from the requirements ----------
    bit m_refneg, m_ref_prev, m_en_q, m_active, m_fwd, m_pair, m_split, m_ph;
    bit m_xlo, m_xhi, m_err, m_seen, m_inv_q;
    int m_cnt, m_ptr, m_en_cnt, m_ref_cnt, m_since;
    bit t_rs, t_rise, t_rfall, t_efall, t_fire;

    always @(negedge clk) m_refneg = rst ? 1'b0 : ref_pulse;

    always @(posedge clk) begin
        if (rst) begin
            m_ref_prev = 0; m_en_q = 0; m_active = 0; m_fwd = 0; m_pair = 0; m_split = 0;
            m_ph = 0; m_xlo = 0; m_xhi = 0; m_err = 0; m_seen = 0; m_inv_q = 0;
            m_cnt = 0; m_ptr = 0; m_en_cnt = 0; m_ref_cnt = 0; m_since = 0;
        end else begin
            t_rs    = ref_on_fall ? m_refneg : ref_pulse;
            t_rise  = t_rs && !m_ref_prev;
            t_rfall = !t_rs && m_ref_prev;
            t_efall = !enable && m_en_q;
            if ((t_efall && m_en_cnt < 30) || (t_rfall && m_ref_cnt < 4) ||
                (t_rise && m_seen && m_since < 60) ||
                ((invert != m_inv_q) && !(t_rise || (m_seen && m_since <= 5))))
                m_err = 1;
            m_en_cnt  = enable ? m_en_cnt + 1 : 0;
            m_ref_cnt = t_rs ? m_ref_cnt + 1 : 0;
            if (t_rise) begin m_since = 1; m_seen = 1; end
            else if (m_seen && m_since < 1000) m_since++;
            m_inv_q = invert;
            t_fire = m_active && m_cnt == 0 && (!m_pair || !m_ph) && m_en_q;
            m_xlo = t_fire && (m_split ? (m_ptr == (m_fwd ? 2 : 0)) : (m_ptr == (m_fwd ? 5 : 0)));
            m_xhi = t_fire && (m_split ? (m_ptr == (m_fwd ? 5 : 3)) : (m_ptr == (m_fwd ? 5 : 0)));
            if (t_rise) begin
                m_fwd = scan_fwd; m_pair = pair_mode; m_split = split_xfer;
                m_cnt = int'(phase_code) + ((pair_mode && slave_sel) ? 1 : 0);
                m_ptr = scan_fwd ? 0 : 5; m_ph = 0; m_active = 1;
            end else if (m_active) begin
                if (m_cnt != 0) m_cnt--;
                else begin
                    if (!m_pair || m_ph) m_ptr = m_fwd ? (m_ptr + 1) % 6 : (m_ptr + 5) % 6;
                    if (m_pair) m_ph = !m_ph;
                end
            end
            m_en_q = enable;
            m_ref_prev = t_rs;
        end
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the expectation
    always @(posedge clk) begin
        logic [5:0] es;
        #4;
        if (!done) begin
            es = (m_active && m_cnt == 0 && (!m_pair || !m_ph) && m_en_q) ? 6'(1 << m_ptr) : 6'd0;
            chk(cur_req, int'(sample_stb), int'(es), "sample_stb");
            chk(cur_req, int'({xfer_lo, xfer_hi, timing_err}),
                int'({m_xlo && m_en_q, m_xhi && m_en_q, m_err}), "xfer/err");
        end
    end

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1; ref_pulse = 0; enable = 0; invert = 0; ref_on_fall = 0;
        scan_fwd = 1; slave_sel = 0; pair_mode = 0; split_xfer = 0; phase_code = 0;
        repeat (2) @(posedge clk);
        #1 rst = 0;
    endtask

    task automatic line(input bit fwd, input bit pair, input bit slv, input bit split,
                        input int code, input int n, input int en_len, input int rw,
                        input bit late, input int inv_at, input int ref2_at, input int chg_at);
        @(posedge clk);
        if (late) #6; else #1;
        ref_pulse = 1; enable = (en_len > 0); scan_fwd = fwd; pair_mode = pair;
        slave_sel = slv; split_xfer = split; phase_code = 4'(code);
        if (inv_at == 0) invert = ~invert;
        for (int i = 1; i <= n; i++) begin
            @(posedge clk); #1;
            if (i == rw) ref_pulse = 0;
            if (i == en_len) enable = 0;
            if (i == inv_at) invert = ~invert;
            if (ref2_at > 0 && i == ref2_at) ref_pulse = 1;
            if (ref2_at > 0 && i == ref2_at + 4) ref_pulse = 0;
            if (i == chg_at) begin
                scan_fwd = ~scan_fwd; phase_code = ~phase_code; split_xfer = ~split_xfer;
            end
            #3;
            cap_s[i] = sample_stb; cap_l[i] = xfer_lo; cap_h[i] = xfer_hi; cap_e[i] = timing_err;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        // R1 reset state
        cur_req = "R1";
        do_reset();
        #3 chk("R1", int'(sample_stb), 0, "stb after reset");
        chk("R1", int'(timing_err), 0, "err after reset");

        // R2 forward order and wrap
        cur_req = "R2";
        line(1, 0, 0, 0, 0, 40, 60, 4, 0, -1, -1, -1);
        chk("R2", cap_s[1], 6'b000001, "first fwd");
        chk("R2", cap_s[6], 6'b100000, "ch6 fwd");
        chk("R2", cap_s[7], 6'b000001, "wrap fwd");
        // R1 reset mid-line clears everything
        @(posedge clk); #1 rst = 1;
        @(posedge clk); #3;
        chk("R1", int'({sample_stb, xfer_lo, xfer_hi, timing_err}), 0, "reset mid-line");
        do_reset();

        // R3 reverse order and wrap
        cur_req = "R3";
        line(0, 0, 0, 0, 0, 40, 60, 4, 0, -1, -1, -1);
        chk("R3", cap_s[1], 6'b100000, "first rev");
        chk("R3", cap_s[2], 6'b010000, "second rev");
        chk("R3", cap_s[7], 6'b100000, "wrap rev");
        do_reset();

        // R6 phase code delay, maximum code
        cur_req = "R6";
        line(1, 0, 0, 0, 9, 40, 60, 4, 0, -1, -1, -1);
        chk("R6", cap_s[9], 0, "code9 before");
        chk("R6", cap_s[10], 6'b000001, "code9 first");
        do_reset();
        line(1, 0, 0, 0, 15, 40, 60, 4, 0, -1, -1, -1);
        chk("R6", cap_s[15], 0, "code15 before");
        chk("R6", cap_s[16], 6'b000001, "code15 first");
        do_reset();

        // R4 / R5 paired mode master and slave
        cur_req = "R4";
        line(1, 1, 0, 0, 0, 40, 60, 4, 0, -1, -1, -1);
        chk("R4", cap_s[1], 6'b000001, "pair master s1");
        chk("R4", cap_s[2], 0, "pair master gap");
        chk("R4", cap_s[3], 6'b000010, "pair master s3");
        do_reset();
        cur_req = "R5";
        line(1, 1, 1, 0, 0, 40, 60, 4, 0, -1, -1, -1);
        chk("R5", cap_s[1], 0, "slave s1");
        chk("R5", cap_s[2], 6'b000001, "slave s2");
        chk("R5", cap_s[4], 6'b000010, "slave s4");
        do_reset();
        line(1, 1, 1, 0, 3, 40, 60, 4, 0, -1, -1, -1);
        chk("R5", cap_s[4], 0, "slave code3 before");
        chk("R5", cap_s[5], 6'b000001, "slave code3 first");
        do_reset();

        // R7 reference sampling edge
        cur_req = "R7";
        ref_on_fall = 0;
        line(1, 0, 0, 0, 0, 40, 60, 4, 1, -1, -1, -1);
        chk("R7", cap_s[1], 6'b000001, "rising sample late ref");
        do_reset();
        ref_on_fall = 1;
        line(1, 0, 0, 0, 0, 40, 60, 4, 1, -1, -1, -1);
        chk("R7", cap_s[1], 0, "falling sample late ref s1");
        chk("R7", cap_s[2], 6'b000001, "falling sample late ref s2");
        do_reset();
        ref_on_fall = 1;
        line(1, 0, 0, 0, 0, 40, 60, 4, 0, -1, -1, -1);
        chk("R7", cap_s[1], 6'b000001, "falling sample early ref");
        do_reset();

        // R8 no enable window
        cur_req = "R8";
        line(1, 0, 0, 0, 0, 20, 0, 4, 0, -1, -1, -1);
        begin
            int any = 0;
            for (int i = 1; i <= 20; i++) any |= int'(cap_s[i]) | int'(cap_l[i]) | int'(cap_h[i]);
            chk("R8", any, 0, "outputs with enable low");
        end
        do_reset();

        // R11 transfers
        cur_req = "R11";
        line(1, 0, 0, 1, 0, 40, 60, 4, 0, -1, -1, -1);
        chk("R11", int'({cap_l[4], cap_h[4]}), 2'b10, "fwd split lo");
        chk("R11", int'({cap_l[7], cap_h[7]}), 2'b01, "fwd split hi");
        do_reset();
        line(1, 0, 0, 0, 0, 40, 60, 4, 0, -1, -1, -1);
        chk("R11", int'({cap_l[4], cap_h[4]}), 2'b00, "fwd joint none");
        chk("R11", int'({cap_l[7], cap_h[7]}), 2'b11, "fwd joint both");
        do_reset();
        line(0, 0, 0, 1, 0, 40, 60, 4, 0, -1, -1, -1);
        chk("R11", int'({cap_l[4], cap_h[4]}), 2'b01, "rev split hi");
        chk("R11", int'({cap_l[7], cap_h[7]}), 2'b10, "rev split lo");
        do_reset();

        // R10 configuration held for the line
        cur_req = "R10";
        line(1, 0, 0, 0, 0, 40, 60, 4, 0, -1, -1, 3);
        chk("R10", cap_s[4], 6'b001000, "dir change ignored");
        chk("R10", int'(cap_l[4]), 0, "split change ignored");
        chk("R10", int'({cap_l[7], cap_h[7]}), 2'b11, "joint kept");
        do_reset();

        // R9 restart mid-sequence (also a spacing violation, R12)
        cur_req = "R9";
        line(1, 0, 0, 0, 0, 30, 60, 4, 0, -1, 20, -1);
        chk("R9", cap_s[20], 6'b000010, "before restart");
        chk("R9", cap_s[21], 6'b000001, "after restart");
        chk("R12", int'(cap_e[21]), 1, "close reference flagged");
        do_reset();

        // R12 limits
        cur_req = "R12";
        line(1, 0, 0, 0, 0, 40, 10, 4, 0, -1, -1, -1);
        chk("R12", int'(cap_e[10]), 0, "short enable before");
        chk("R12", int'(cap_e[11]), 1, "short enable flagged");
        chk("R8", int'(cap_s[11]), 0, "stb after enable drop");
        do_reset();
        line(1, 0, 0, 0, 0, 40, 60, 3, 0, -1, -1, -1);
        chk("R12", int'(cap_e[3]), 0, "ref 3 before");
        chk("R12", int'(cap_e[4]), 1, "ref 3 flagged");
        do_reset();
        line(1, 0, 0, 0, 0, 40, 30, 4, 0, -1, -1, -1);
        chk("R12", int'(cap_e[40]), 0, "legal widths at limit");
        do_reset();
        line(1, 0, 0, 0, 0, 59, 40, 4, 0, -1, -1, -1);
        line(1, 0, 0, 0, 0, 10, 60, 4, 0, -1, -1, -1);
        chk("R12", int'(cap_e[1]), 0, "spacing 60 legal");
        do_reset();
        line(1, 0, 0, 0, 0, 58, 40, 4, 0, -1, -1, -1);
        line(1, 0, 0, 0, 0, 10, 60, 4, 0, -1, -1, -1);
        chk("R12", int'(cap_e[1]), 1, "spacing 59 flagged");
        do_reset();

        // R13 invert changes
        cur_req = "R13";
        line(1, 0, 0, 0, 0, 30, 60, 4, 0, 5, -1, -1);
        chk("R13", int'(cap_e[30]), 0, "invert at 5 legal");
        do_reset();
        line(1, 0, 0, 0, 0, 30, 60, 4, 0, 6, -1, -1);
        chk("R13", int'(cap_e[6]), 0, "invert at 6 before");
        chk("R13", int'(cap_e[7]), 1, "invert at 6 flagged");
        do_reset();
        line(1, 0, 0, 0, 0, 30, 60, 4, 0, 20, -1, -1);
        chk("R13", int'(cap_e[21]), 1, "stray invert flagged");
        chk("R13", cap_s[21], 6'b000100, "sequence continues");
        do_reset();

        // random legal lines, all configurations
        cur_req = "R4";
        for (int k = 0; k < 40; k++) begin
            int n, en_len, rw, inv_at;
            n = 60 + int'($urandom % 30);
            en_len = 30 + int'($urandom % (n - 31));
            rw = 4 + int'($urandom % 8);
            inv_at = ($urandom % 3 == 0) ? int'($urandom % 6) : -1;
            ref_on_fall = 1'($urandom);
            line(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 int'($urandom % 16), n, en_len, rw, 0, inv_at, -1, -1);
        end
        #1 chk("R12", int'(timing_err), 0, "no false alarm on legal input");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule